// File: doc/BRIEF.md
# Auto-Reloading DMA Channel Sequencer

This block is one DMA channel. It keeps three working counters: a source address (side A), a destination address (side B) and a remaining transfer count. Each counter has a shadow reload value. The channel also has a control word, a status word and a small register port that software uses to program all of them. When a peripheral raises its request line, or when software sets the software request bit, the channel issues one transfer on a valid/ready bus. After each transfer it advances the addresses and decrements the count.

In memory-to-memory (indirect) mode, a transfer is a read from side A followed by a write of the captured data to side B. In fly-by (direct) mode, a transfer is a single write strobe at side A. That strobe completes with an acknowledge pulse to the requesting peripheral, and side B is left untouched.

When the count runs out, the channel does one of two things. It can reload its counters from the shadows and carry on: always in auto-reload mode, and once per software-marked valid reload set in single-shot mode. Otherwise it stops and flags an overflow. Status bits drive a level interrupt that stays high until software clears it. The freeze input stalls the channel for debug.

Bus back-pressure follows these rules:
- A transfer beat completes on a cycle where `bus_valid` and `bus_ready` are both high.
- Once `bus_valid` is raised, the address, direction and data hold until `bus_ready` accepts the beat.
- `bus_valid` may drop without a handshake only while `freeze` is high, or after the channel is disabled. In both cases nothing is counted.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, every register reads zero, `bus_valid` and `irq` are low and `hw_ack` is low.
- R2: With control bit 5 (indirect) set, each request produces a read beat (`bus_write`=0) at counter A. It is followed by a write beat (`bus_write`=1) at counter B that carries the data read. After the write handshake, A and B each advance by STEP (1), and the count drops by one.
- R3: With bit 5 clear, each request produces one write beat at counter A. `hw_ack` pulses with its handshake when the transfer was started by `hw_req`. Counter B and its reload are neither used nor changed.
- R4: When a write handshake takes the count from 1 to the end of the block and a reload applies, A, count and (in indirect mode only) B are loaded from their shadows on that same edge.
- R5: At a reload, status bit 1 (terminal count) is set if it was clear. If it was already set, status bit 2 (overflow) is set instead. Transfers continue either way.
- R6: In single-shot mode (control bit 1 clear), a block end reloads only if status bit 3 (reload valid) is set, and then clears bit 3. If bit 3 is clear, the channel sets overflow, clears status bit 0 (active) and issues no more transfers.
- R7: Writing 1 to status bit 1 or 2 clears that bit, and a hardware set on the same edge wins. Writing 1 to bit 3 sets it. `irq` = (bit1 AND control bit 3) OR (bit2 AND control bit 4), and it falls only after a register write.
- R8: Control bit 2 (software request) acts as a level request while set. Once it is cleared, no new transfer starts.
- R9: While `freeze` is high, `bus_valid` is low and no counter changes. Operation resumes from the same point when `freeze` falls.
- R10: Writing the control word sets active to control bit 0 (enable). When enable is cleared, an unfinished transfer is dropped with `bus_valid` low from the next cycle, and no counters change.
- R11: While `bus_valid` is high and `bus_ready` is low, `bus_addr`, `bus_write` and `bus_wdata` hold until the next cycle unless `freeze` rises or the channel is disabled.
- R12: The register port indices are: 0 control, 1 status {reload-valid, overflow, terminal-count, active}, 2 counter A, 3 reload A, 4 counter B, 5 reload B, 6 count, 7 reload count. Reads are combinational, and writes take effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_idx` |
| hw_req | input | 1 | Peripheral transfer request (level) |
| hw_ack | output | 1 | Acknowledge of a hardware-requested transfer |
| freeze | input | 1 | Debug stall |
| bus_valid | output | 1 | Beat valid |
| bus_ready | input | 1 | Beat accepted |
| bus_write | output | 1 | 1 for write beat, 0 for read beat |
| bus_addr | output | AW | Beat address |
| bus_wdata | output | DW | Write data (zero in direct mode) |
| bus_rdata | input | DW | Read data, sampled on read handshake |
| irq | output | 1 | Level interrupt |

## Verification
A request seen at a clock edge raises `bus_valid` in the next cycle. An indirect write beat follows one edge after the read handshake. Counters, status and the reload all change on the edge of the write handshake. `irq` and register reads follow the register state with no added delay, and `hw_ack` is combinational with its handshake. The bench therefore updates a behavioural model on each rising edge from the same inputs the design samples. It drives new inputs at the falling edge and compares every output, including the register addressed that cycle, shortly after that edge.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RD   = 2'd1,
    PH_WR   = 2'd2
  } phase_e;

  // control word, bit 0 at the bottom
  typedef struct packed {
    logic indir;
    logic ovie;
    logic tcie;
    logic swreq;
    logic autold;
    logic en;
  } ctl_t;

  localparam int CTL_W = 6;

  localparam logic [2:0] REG_CTL  = 3'd0;
  localparam logic [2:0] REG_ST   = 3'd1;
  localparam logic [2:0] REG_A    = 3'd2;
  localparam logic [2:0] REG_RA   = 3'd3;
  localparam logic [2:0] REG_B    = 3'd4;
  localparam logic [2:0] REG_RB   = 3'd5;
  localparam logic [2:0] REG_LEN  = 3'd6;
  localparam logic [2:0] REG_RLEN = 3'd7;

  localparam int ST_ACT = 0;
  localparam int ST_TC  = 1;
  localparam int ST_OVF = 2;
  localparam int ST_RV  = 3;

endpackage

// File: rtl/dma_seq_regs.sv
module dma_seq_regs
  import dma_seq_pkg::*;
#(
  parameter int AW   = 16,
  parameter int LW   = 16,
  parameter int STEP = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          freeze,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_idx,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          xfer_done,
  output ctl_t          ctl_o,
  output logic          active_o,
  output logic [AW-1:0] cnt_a_o,
  output logic [AW-1:0] cnt_b_o,
  output logic          irq
);

  localparam logic [AW-1:0] ADDR_INC = AW'(STEP);
  localparam logic [LW-1:0] LEN_ONE  = LW'(1);

  ctl_t          ctl;
  logic          act, tc, ovf, rv;
  logic [AW-1:0] cnt_a, cnt_b, rld_a, rld_b;
  logic [LW-1:0] cnt_len, rld_len;

  logic [7:0]    wr_sel;
  logic          blk_end, do_reload, do_stop, set_tc, set_ovf;

  logic          act_n, tc_n, ovf_n, rv_n;
  logic [AW-1:0] a_n, b_n;
  logic [LW-1:0] len_n;

  genvar gi;
  generate
    for (gi = 0; gi < 8; gi++) begin : g_sel
      assign wr_sel[gi] = cfg_we && (cfg_idx == 3'(gi));
    end
  endgenerate

  assign blk_end   = xfer_done && (cnt_len == LEN_ONE);
  assign do_reload = blk_end && (ctl.autold || rv);
  assign do_stop   = blk_end && !do_reload;
  assign set_tc    = do_reload && !tc;
  assign set_ovf   = (do_reload && tc) || do_stop;

  always_comb begin
    if (wr_sel[REG_A])    a_n = cnt_a;
    else                  a_n = cnt_a;
    if (wr_sel[REG_A])          a_n = cfg_wdata[AW-1:0];
    else if (do_reload)         a_n = rld_a;
    else if (xfer_done)         a_n = cnt_a + ADDR_INC;

    b_n = cnt_b;
    if (wr_sel[REG_B])                      b_n = cfg_wdata[AW-1:0];
    else if (do_reload && ctl.indir)        b_n = rld_b;
    else if (xfer_done && ctl.indir)        b_n = cnt_b + ADDR_INC;

    len_n = cnt_len;
    if (wr_sel[REG_LEN])        len_n = cfg_wdata[LW-1:0];
    else if (do_reload)         len_n = rld_len;
    else if (xfer_done)         len_n = cnt_len - LEN_ONE;

    tc_n  = (tc  && !(wr_sel[REG_ST] && cfg_wdata[ST_TC]))  || set_tc;
    ovf_n = (ovf && !(wr_sel[REG_ST] && cfg_wdata[ST_OVF])) || set_ovf;

    rv_n = rv;
    if (wr_sel[REG_ST] && cfg_wdata[ST_RV]) rv_n = 1'b1;
    else if (do_reload && !ctl.autold)      rv_n = 1'b0;

    act_n = act;
    if (wr_sel[REG_CTL])   act_n = cfg_wdata[0];
    else if (do_stop)      act_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl     <= '0;
      act     <= 1'b0;
      tc      <= 1'b0;
      ovf     <= 1'b0;
      rv      <= 1'b0;
      cnt_a   <= '0;
      cnt_b   <= '0;
      cnt_len <= '0;
      rld_a   <= '0;
      rld_b   <= '0;
      rld_len <= '0;
    end else begin
      if (wr_sel[REG_CTL])  ctl     <= ctl_t'(cfg_wdata[CTL_W-1:0]);
      if (wr_sel[REG_RA])   rld_a   <= cfg_wdata[AW-1:0];
      if (wr_sel[REG_RB])   rld_b   <= cfg_wdata[AW-1:0];
      if (wr_sel[REG_RLEN]) rld_len <= cfg_wdata[LW-1:0];
      act     <= act_n;
      tc      <= tc_n;
      ovf     <= ovf_n;
      rv      <= rv_n;
      cnt_a   <= a_n;
      cnt_b   <= b_n;
      cnt_len <= len_n;
    end
  end

  always_comb begin
    case (cfg_idx)
      REG_CTL:  cfg_rdata = 32'(ctl);
      REG_ST:   cfg_rdata = {28'd0, rv, ovf, tc, act};
      REG_A:    cfg_rdata = 32'(cnt_a);
      REG_RA:   cfg_rdata = 32'(rld_a);
      REG_B:    cfg_rdata = 32'(cnt_b);
      REG_RB:   cfg_rdata = 32'(rld_b);
      REG_LEN:  cfg_rdata = 32'(cnt_len);
      default:  cfg_rdata = 32'(rld_len);
    endcase
  end

  assign ctl_o    = ctl;
  assign active_o = act;
  assign cnt_a_o  = cnt_a;
  assign cnt_b_o  = cnt_b;
  assign irq      = (tc && ctl.tcie) || (ovf && ctl.ovie);

  // R4
  reload_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_reload && !cfg_we) |=> (cnt_len == $past(rld_len) && cnt_a == $past(rld_a)));

  // R6
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_stop && !wr_sel[REG_CTL]) |=> (!act && ovf));

  // R9
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !cfg_we) |=> ($stable(cnt_a) && $stable(cnt_b) && $stable(cnt_len)));

  // R7
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(cfg_we));

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          freeze,
  input  logic          hw_req,
  input  logic          active_i,
  input  ctl_t          ctl_i,
  input  logic [AW-1:0] cnt_a,
  input  logic [AW-1:0] cnt_b,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          hw_ack,
  output logic          xfer_done
);

  phase_e        state;
  logic          src_hw;
  logic [DW-1:0] data_q;
  logic          hs, want;

  assign want      = hw_req || ctl_i.swreq;
  assign bus_valid = (state != PH_IDLE) && active_i && !freeze;
  assign hs        = bus_valid && bus_ready;
  assign bus_write = (state == PH_WR);
  assign bus_addr  = (state == PH_WR && ctl_i.indir) ? cnt_b : cnt_a;
  assign bus_wdata = ctl_i.indir ? data_q : '0;
  assign xfer_done = hs && (state == PH_WR);
  assign hw_ack    = xfer_done && src_hw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= PH_IDLE;
      src_hw <= 1'b0;
      data_q <= '0;
    end else begin
      case (state)
        PH_IDLE: begin
          if (active_i && !freeze && want) begin
            src_hw <= hw_req;
            state  <= ctl_i.indir ? PH_RD : PH_WR;
          end
        end
        PH_RD: begin
          if (!active_i) state <= PH_IDLE;
          else if (hs) begin
            data_q <= bus_rdata;
            state  <= PH_WR;
          end
        end
        PH_WR: begin
          if (!active_i) state <= PH_IDLE;
          else if (hs)   state <= PH_IDLE;
        end
        default: state <= PH_IDLE;
      endcase
    end
  end

  // R11
  hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=>
      (!bus_valid || ($stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata))));

  // R10
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_i && state != PH_IDLE) |=> (state == PH_IDLE));

  // R3
  ack_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_ack |-> (bus_write && bus_ready && !freeze));

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int AW   = 16,
  parameter int LW   = 16,
  parameter int DW   = 16,
  parameter int STEP = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_idx,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          hw_req,
  output logic          hw_ack,
  input  logic          freeze,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          irq
);

  ctl_t          ctl;
  logic          active;
  logic [AW-1:0] cnt_a, cnt_b;
  logic          xfer_done;

  dma_seq_regs #(.AW(AW), .LW(LW), .STEP(STEP)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .freeze    (freeze),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .xfer_done (xfer_done),
    .ctl_o     (ctl),
    .active_o  (active),
    .cnt_a_o   (cnt_a),
    .cnt_b_o   (cnt_b),
    .irq       (irq)
  );

  dma_seq_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .freeze    (freeze),
    .hw_req    (hw_req),
    .active_i  (active),
    .ctl_i     (ctl),
    .cnt_a     (cnt_a),
    .cnt_b     (cnt_b),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .hw_ack    (hw_ack),
    .xfer_done (xfer_done)
  );

endmodule

// File: tb/dma_chan_seq_bench.sv
module dma_chan_seq_bench;
  localparam int CLK_NS = 10;
  localparam logic [15:0] RD_PAT = 16'h5A3C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = 3'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic [31:0] cfg_rdata;
  logic        hw_req = 1'b0;
  logic        hw_ack;
  logic        freeze = 1'b0;
  logic        bus_valid;
  logic        bus_ready = 1'b0;
  logic        bus_write;
  logic [15:0] bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        irq;

  always #(CLK_NS/2) clk = ~clk;
  assign bus_rdata = bus_addr ^ RD_PAT;

  dma_chan_seq u_dma_chan_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .hw_req(hw_req),
    .hw_ack(hw_ack), .freeze(freeze), .bus_valid(bus_valid),
    .bus_ready(bus_ready), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  // reference model state
  bit m_en, m_auto, m_sw, m_tie, m_oie, m_ind;
  bit m_act, m_tc, m_ovf, m_rv, m_src;
  int m_ph;
  logic [15:0] m_a, m_b, m_len, m_ra, m_rb, m_rlen, m_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_en, m_auto, m_sw, m_tie, m_oie, m_ind} = '0;
      {m_act, m_tc, m_ovf, m_rv, m_src} = '0;
      m_ph = 0;
      {m_a, m_b, m_len, m_ra, m_rb, m_rlen, m_data} = '0;
    end else begin
      bit v, hs, done, be, rel, stp, ntc, novf, nrv, nact;
      int nph;
      logic [15:0] na, nb, nl;
      v    = (m_ph != 0) && m_act && !freeze;
      hs   = v && bus_ready;
      done = hs && (m_ph == 2);
      nph  = m_ph;
      if (m_ph == 0) begin
        if (m_act && !freeze && (hw_req || m_sw)) begin
          m_src = hw_req;
          nph = m_ind ? 1 : 2;
        end
      end else if (!m_act) nph = 0;
      else if (hs) begin
        if (m_ph == 1) begin m_data = m_a ^ RD_PAT; nph = 2; end
        else nph = 0;
      end
      be  = done && (m_len == 16'd1);
      rel = be && (m_auto || m_rv);
      stp = be && !rel;
      na = m_a; nb = m_b; nl = m_len;
      ntc = m_tc; novf = m_ovf; nrv = m_rv; nact = m_act;
      if (rel) begin
        na = m_ra; nl = m_rlen;
        if (m_ind) nb = m_rb;
        if (m_tc) novf = 1; else ntc = 1;
        if (!m_auto) nrv = 0;
      end else if (done) begin
        na = m_a + 16'd1; nl = m_len - 16'd1;
        if (m_ind) nb = m_b + 16'd1;
      end
      if (stp) begin novf = 1; nact = 0; end
      if (cfg_we) begin
        case (cfg_idx)
          3'd0: begin
            {m_ind, m_oie, m_tie, m_sw, m_auto, m_en} = cfg_wdata[5:0];
            nact = cfg_wdata[0];
          end
          3'd1: begin
            if (cfg_wdata[1]) ntc = rel && !m_tc;
            if (cfg_wdata[2]) novf = (rel && m_tc) || stp;
            if (cfg_wdata[3]) nrv = 1;
          end
          3'd2: na = cfg_wdata[15:0];
          3'd3: m_ra = cfg_wdata[15:0];
          3'd4: nb = cfg_wdata[15:0];
          3'd5: m_rb = cfg_wdata[15:0];
          3'd6: nl = cfg_wdata[15:0];
          default: m_rlen = cfg_wdata[15:0];
        endcase
      end
      m_a = na; m_b = nb; m_len = nl;
      m_tc = ntc; m_ovf = novf; m_rv = nrv; m_act = nact; m_ph = nph;
    end
  end

  task automatic check(input bit ok, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  bit last_ack = 0;

  task automatic compare();
    bit e_valid, e_write, e_ack, e_irq;
    logic [15:0] e_addr, e_wdata;
    logic [31:0] e_rd;
    e_valid = (m_ph != 0) && m_act && !freeze;
    e_write = (m_ph == 2);
    e_addr  = (m_ph == 2 && m_ind) ? m_b : m_a;
    e_wdata = m_ind ? m_data : 16'd0;
    e_ack   = e_valid && bus_ready && e_write && m_src;
    e_irq   = (m_tc && m_tie) || (m_ovf && m_oie);
    case (cfg_idx)
      3'd0: e_rd = {26'd0, m_ind, m_oie, m_tie, m_sw, m_auto, m_en};
      3'd1: e_rd = {28'd0, m_rv, m_ovf, m_tc, m_act};
      3'd2: e_rd = {16'd0, m_a};
      3'd3: e_rd = {16'd0, m_ra};
      3'd4: e_rd = {16'd0, m_b};
      3'd5: e_rd = {16'd0, m_rb};
      3'd6: e_rd = {16'd0, m_len};
      default: e_rd = {16'd0, m_rlen};
    endcase
    check(bus_valid === e_valid, "bus_valid", 32'(bus_valid), 32'(e_valid));
    if (e_valid) begin
      check(bus_write === e_write, "bus_write", 32'(bus_write), 32'(e_write));
      check(bus_addr === e_addr, "bus_addr", 32'(bus_addr), 32'(e_addr));
      if (e_write) check(bus_wdata === e_wdata, "bus_wdata", 32'(bus_wdata), 32'(e_wdata));
    end
    check(hw_ack === e_ack, "hw_ack", 32'(hw_ack), 32'(e_ack));
    check(irq === e_irq, "irq", 32'(irq), 32'(e_irq));
    check(cfg_rdata === e_rd, $sformatf("reg%0d", cfg_idx), cfg_rdata, e_rd);
    last_ack = e_ack;
  endtask

  int rmode = 0;
  bit fmode = 0;
  bit hw_mode = 0;
  int gap = 0;
  logic [2:0] rd_idx = 3'd0;

  task automatic drive_common();
    case (rmode)
      0: bus_ready = 1'b1;
      1: bus_ready = ($urandom % 4) != 0;
      default: bus_ready = ($urandom % 5) == 0;
    endcase
    freeze = fmode ? (($urandom % 3) == 0) : 1'b0;
    if (last_ack) begin hw_req = 1'b0; gap = 2; end
    else if (hw_mode && !hw_req) begin
      if (gap > 0) gap--; else hw_req = 1'b1;
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cfg_we = 1'b0;
      cfg_idx = rd_idx;
      rd_idx = rd_idx + 3'd1;
      drive_common();
      #1 compare();
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] val);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_idx = idx;
    cfg_wdata = val;
    drive_common();
    #1 compare();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values of every register and output
    tag = "R1"; run(9);

    // R2 indirect transfers, ends in R6 stop with overflow
    tag = "R2"; rmode = 1;
    wr(3'd2, 32'h0100); wr(3'd4, 32'h0200); wr(3'd6, 32'd3);
    wr(3'd0, 32'h35);
    run(30);
    tag = "R6"; run(5);

    // R7 write-1-to-clear, irq falls after the write
    tag = "R7"; wr(3'd1, 32'h6); run(4);

    // R4 reload of all counters, R5 tc then overflow
    tag = "R4";
    wr(3'd2, 32'h10); wr(3'd3, 32'h40); wr(3'd4, 32'h80); wr(3'd5, 32'hC0);
    wr(3'd6, 32'd2); wr(3'd7, 32'd3);
    wr(3'd0, 32'h3F);
    run(25);
    tag = "R5"; run(30);

    // R9 random freeze
    tag = "R9"; fmode = 1; run(60); fmode = 0;

    // R8 software request withdrawn
    tag = "R8"; wr(3'd0, 32'h3B); run(15);
    tag = "R7"; wr(3'd1, 32'h6); run(3);

    // R10 abort by clearing enable mid transfer
    tag = "R10"; rmode = 2;
    wr(3'd0, 32'h3F); run(3); wr(3'd0, 32'h00); run(10);

    // R3 direct mode with peripheral handshake
    tag = "R3"; rmode = 1;
    wr(3'd2, 32'h300); wr(3'd3, 32'h300); wr(3'd4, 32'h555);
    wr(3'd6, 32'd4); wr(3'd7, 32'd4);
    wr(3'd0, 32'h0B);
    hw_mode = 1; run(60); hw_mode = 0; run(20);

    // R6 single-shot with reload-valid set once
    tag = "R6";
    wr(3'd0, 32'h00); wr(3'd1, 32'h6);
    wr(3'd2, 32'h20); wr(3'd3, 32'h20); wr(3'd4, 32'h60); wr(3'd5, 32'h60);
    wr(3'd6, 32'd2); wr(3'd7, 32'd2);
    wr(3'd1, 32'h8);
    wr(3'd0, 32'h35);
    run(50);

    // R11 heavy back-pressure with freeze
    tag = "R11"; rmode = 2;
    wr(3'd0, 32'h3F); run(40);
    fmode = 1; run(30); fmode = 0;

    // R12 final register readback
    tag = "R12"; rmode = 0;
    wr(3'd0, 32'h00); run(16);

    finish_run();
  end
endmodule